// File: doc/BRIEF.md
# Serial SAR Converter Interface Sequencer

This block is a synthesizable digital stand-in for the control and serial readout logic of a 12-bit successive-approximation converter. It runs on a fast system clock and observes two slow external inputs: an active-low select line, which also acts as a shutdown control, and a data clock driven by the host. The analog input is represented by a digital sample word. A trial-code register and a magnitude comparator resolve that sample one bit per data-clock period.

A falling select edge opens a read. Two falling data-clock edges form the sampling phase. The sample is then captured and a low null bit is driven. Each of the next twelve falling edges resolves one result bit, starting at the top bit, and puts it on the output at once. After the lowest bit, the word is sent again from bit 1 up to bit 11, and the output is then released. Raising the select line at any point ends the read, so a host can stop after as many bits as it needs. Two flags report the power state: the analog section is idle once all bits are decided, and the whole block is idle while the select line is high.

Top module: `sar_serial_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the block enters full power-down: dout_oe=0, dout=0, pd_full=1, pd_analog=0.
- R2: A read starts only on a high-to-low transition of cs_n_in. Data-clock edges while cs_n_in is high leave dout_oe at 0 and pd_full at 1.
- R3: The first falling data-clock edge after the read starts leaves dout_oe=0. The second falling edge captures sample_in, sets dout_oe=1 and drives dout=0 (the null bit).
- R4: Falling edges 3 to 14 present result bits 11 down to 0 in that order. Each bit is the decision made at that same edge.
- R5: Falling edges 15 to 25 present result bits 1 up to 11 in that order, which repeats the word lowest bit first.
- R6: Falling edge 26 sets dout_oe=0. Later falling edges while cs_n_in stays low do not enable the output again.
- R7: A rise of cs_n_in at any point sets dout_oe=0 and pd_full=1 within 4 system clocks, which ends the read.
- R8: The result is straight binary and equals the captured sample word: 12'h000 gives 12'h000, 12'h800 gives 12'h800, 12'hFFF gives 12'hFFF.
- R9: pd_analog rises at the edge that decides bit 0 and stays high until cs_n_in rises. pd_full is high only while the synchronized select line is high.
- R10: At each decision, the trial code is the bits kept so far with the current bit set. The bit is kept when sample >= trial and cleared otherwise, so the adjacent codes 12'h7FF and 12'h800 resolve exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the data clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_in | input | 1 | Asynchronous select, low active; high means shutdown |
| dclk_in | input | 1 | Asynchronous host data clock |
| sample_in | input | 12 | Digital stand-in for the analog input |
| dout | output | 1 | Serial result bit |
| dout_oe | output | 1 | High when dout is driven (stands in for tri-state) |
| pd_analog | output | 1 | Analog section idle: all bits decided |
| pd_full | output | 1 | Whole block in shutdown |

## Verification
The bench targets the off-by-one edges of the readout. If the null bit or the sampling phase is counted wrong, every bit moves by one position and each word compare fails. If the repeat phase is off by one, the output is released early or late, or bit 0 is sent twice. Codes 12'h7FF and 12'h800 test the comparator: using a strict compare, or a missing trial bit, gives a word one LSB off. Two more cases are covered: a read aborted mid-word, which must release the output, and data-clock edges after the word ends or while the select line is high, which must not restart the read.

// File: rtl/sar_seq_pkg.sv
// Shared types for the serial SAR sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package sar_seq_pkg;
    typedef enum logic [2:0] {
        ST_OFF,     // select high: full shutdown
        ST_SAMPLE,  // counting the two sampling-phase edges
        ST_CONV,    // resolving one bit per falling edge
        ST_REPEAT,  // resending the word lowest bit first
        ST_DONE     // output released, waiting for select to cycle
    } seq_state_t;
endpackage

// File: rtl/sar_edge_sync.sv
// Brings the select line and the data clock into the system clock domain
// and flags falling edges. Assumes both inputs stay stable for several
// system clocks per level. Idle level of both is high after reset.
module sar_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_in,
    input  logic dclk_in,
    output logic cs_n_s,
    output logic cs_fall,
    output logic dclk_fall
);
    logic [STAGES-1:0] cs_sh;
    logic [STAGES-1:0] dk_sh;
    logic              cs_prev;
    logic              dk_prev;

    // Synchronizer chains plus one extra stage each for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_sh   <= '1;
            dk_sh   <= '1;
            cs_prev <= 1'b1;
            dk_prev <= 1'b1;
        end else begin
            cs_sh   <= {cs_sh[STAGES-2:0], cs_n_in};
            dk_sh   <= {dk_sh[STAGES-2:0], dclk_in};
            cs_prev <= cs_sh[STAGES-1];
            dk_prev <= dk_sh[STAGES-1];
        end
    end

    assign cs_n_s    = cs_sh[STAGES-1];
    assign cs_fall   = cs_prev & ~cs_sh[STAGES-1];
    assign dclk_fall = dk_prev & ~dk_sh[STAGES-1];

    // R4: an edge pulse lasts one system clock, so no bit is decided twice.
    a_r4_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_fall |=> !dclk_fall);
endmodule

// File: rtl/sar_bit_engine.sv
// Holds the captured sample and the trial code, and makes one bit decision
// per step. Assumes bits are stepped from the top down after each load,
// so all bits below the current one are still zero.
module sar_bit_engine #(
    parameter int NBITS = 12,
    localparam int IW = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [IW-1:0]    bit_idx,
    input  logic [NBITS-1:0] sample_in,
    output logic [NBITS-1:0] code,
    output logic             decision
);
    logic [NBITS-1:0] held;
    logic [NBITS-1:0] trial;

    // Trial code: bits kept so far with the current bit set.
    always_comb begin
        trial    = code | ({{(NBITS-1){1'b0}}, 1'b1} << bit_idx);
        decision = (held >= trial);
    end

    // Capture the sample on load, keep or clear the current bit on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
            code <= '0;
        end else if (load) begin
            held <= sample_in;
            code <= '0;
        end else if (step) begin
            code <= decision ? trial : code;
        end
    end

    // R10: the kept code never exceeds the held sample.
    a_r10_code_bound: assert property (@(posedge clk) disable iff (!rst_n)
        code <= held);
    // R10: a decision never lowers the code.
    a_r10_code_rising: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> code >= $past(code));
endmodule

// File: rtl/sar_out_seq.sv
// Serial readout sequencer: counts falling data-clock edges after a select
// fall, drives the null bit, the top-first word, the repeated word and the
// release, and keeps the power flags. Assumes synchronized inputs.
module sar_out_seq
    import sar_seq_pkg::*;
#(
    parameter int NBITS = 12,
    localparam int IW = $clog2(NBITS),
    localparam int CW = $clog2(NBITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_s,
    input  logic             cs_fall,
    input  logic             dclk_fall,
    input  logic             decision,
    input  logic [NBITS-1:0] code,
    output logic             load,
    output logic             step,
    output logic [IW-1:0]    bit_idx,
    output logic             dout,
    output logic             dout_oe,
    output logic             pd_analog,
    output logic             pd_full
);
    seq_state_t    state;
    logic [CW-1:0] idx;
    logic          first_seen;

    assign load    = (state == ST_SAMPLE) && dclk_fall && first_seen;
    assign step    = (state == ST_CONV) && dclk_fall;
    assign bit_idx = idx[IW-1:0];
    assign pd_full = (state == ST_OFF);

    // Edge-driven readout state machine; select high overrides everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_OFF;
            idx        <= '0;
            first_seen <= 1'b0;
            dout       <= 1'b0;
            dout_oe    <= 1'b0;
            pd_analog  <= 1'b0;
        end else if (cs_n_s) begin
            state      <= ST_OFF;
            first_seen <= 1'b0;
            dout       <= 1'b0;
            dout_oe    <= 1'b0;
            pd_analog  <= 1'b0;
        end else begin
            case (state)
                ST_OFF: begin
                    if (cs_fall) state <= ST_SAMPLE;
                end
                ST_SAMPLE: begin
                    if (dclk_fall) begin
                        if (first_seen) begin
                            state   <= ST_CONV;
                            idx     <= CW'(NBITS - 1);
                            dout    <= 1'b0;
                            dout_oe <= 1'b1;
                        end else begin
                            first_seen <= 1'b1;
                        end
                    end
                end
                ST_CONV: begin
                    if (dclk_fall) begin
                        dout <= decision;
                        if (idx == '0) begin
                            state     <= ST_REPEAT;
                            idx       <= CW'(1);
                            pd_analog <= 1'b1;
                        end else begin
                            idx <= idx - 1'b1;
                        end
                    end
                end
                ST_REPEAT: begin
                    if (dclk_fall) begin
                        if (idx == CW'(NBITS)) begin
                            state   <= ST_DONE;
                            dout    <= 1'b0;
                            dout_oe <= 1'b0;
                        end else begin
                            dout <= code[idx[IW-1:0]];
                            idx  <= idx + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: the first driven bit of a read is the low null bit.
    a_r3_null_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> !dout);
    // R7: select high releases the output and enters shutdown next clock.
    a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (!dout_oe && pd_full));
    // R6: once released, the output stays off while select stays low.
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !cs_n_s) |=> !dout_oe);
    // R9: the two power flags never show together.
    a_r9_pd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pd_full && pd_analog));
endmodule

// File: rtl/sar_serial_seq.sv
// Top of the serial SAR interface sequencer: synchronizer, readout
// sequencer and bit engine. Assumes the data clock half period spans
// at least four system clocks.
module sar_serial_seq #(
    parameter int NBITS       = 12,
    parameter int SYNC_STAGES = 2,
    localparam int IW = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_in,
    input  logic             dclk_in,
    input  logic [NBITS-1:0] sample_in,
    output logic             dout,
    output logic             dout_oe,
    output logic             pd_analog,
    output logic             pd_full
);
    logic             cs_n_s;
    logic             cs_fall;
    logic             dclk_fall;
    logic             load;
    logic             step;
    logic             decision;
    logic [IW-1:0]    bit_idx;
    logic [NBITS-1:0] code;

    sar_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_in   (cs_n_in),
        .dclk_in   (dclk_in),
        .cs_n_s    (cs_n_s),
        .cs_fall   (cs_fall),
        .dclk_fall (dclk_fall)
    );

    sar_out_seq #(.NBITS(NBITS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .cs_fall   (cs_fall),
        .dclk_fall (dclk_fall),
        .decision  (decision),
        .code      (code),
        .load      (load),
        .step      (step),
        .bit_idx   (bit_idx),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .pd_analog (pd_analog),
        .pd_full   (pd_full)
    );

    sar_bit_engine #(.NBITS(NBITS)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .bit_idx   (bit_idx),
        .sample_in (sample_in),
        .code      (code),
        .decision  (decision)
    );

    // R2: the output is only driven outside shutdown.
    a_r2_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> !pd_full);
endmodule

// File: tb/sar_serial_seq_bench.sv
module sar_serial_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n_in = 1'b1;
    logic        dclk_in = 1'b1;
    logic [11:0] sample_in = '0;
    logic        dout, dout_oe, pd_analog, pd_full;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam int NVEC = 8;
    localparam logic [11:0] VEC_IN  [NVEC] = '{12'h000, 12'h800, 12'hFFF, 12'h7FF,
                                              12'hA5A, 12'h001, 12'h555, 12'h123};
    localparam logic [11:0] VEC_EXP [NVEC] = '{12'h000, 12'h800, 12'hFFF, 12'h7FF,
                                              12'hA5A, 12'h001, 12'h555, 12'h123};

    always #4 clk = ~clk;

    sar_serial_seq u_sar_serial_seq (
        .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .dclk_in(dclk_in),
        .sample_in(sample_in), .dout(dout), .dout_oe(dout_oe),
        .pd_analog(pd_analog), .pd_full(pd_full)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One data-clock period: falling edge, low half, rising edge, high half.
    task automatic dpulse();
        dclk_in = 1'b0;
        repeat (8) @(negedge clk);
        dclk_in = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // A full read of one sample; returns both words as seen on dout.
    task automatic full_read(input logic [11:0] s, output logic [11:0] msbw,
                             output logic [11:0] rep, output bit oe_ok);
        sample_in = s;
        oe_ok = 1'b1;
        msbw = '0;
        rep = '0;
        cs_n_in = 1'b0;
        repeat (8) @(negedge clk);
        dpulse();
        if (dout_oe !== 1'b0) oe_ok = 1'b0;
        dpulse();
        if (dout_oe !== 1'b1 || dout !== 1'b0) oe_ok = 1'b0;
        for (int k = 11; k >= 0; k--) begin
            dpulse();
            msbw[k] = dout;
            if (dout_oe !== 1'b1) oe_ok = 1'b0;
        end
        check(pd_analog === 1'b1 && pd_full === 1'b0, "R9 pd_analog after bit 0",
              {pd_analog, pd_full}, 2'b10);
        for (int k = 1; k <= 11; k++) begin
            dpulse();
            rep[k] = dout;
            if (dout_oe !== 1'b1) oe_ok = 1'b0;
        end
        dpulse();
        check(dout_oe === 1'b0, "R6 release after repeated bit 11", dout_oe, 0);
        dpulse();
        dpulse();
        check(dout_oe === 1'b0 && pd_analog === 1'b1, "R6 later edges have no effect",
              {dout_oe, pd_analog}, 2'b01);
        cs_n_in = 1'b1;
        repeat (8) @(negedge clk);
        check(pd_full === 1'b1 && pd_analog === 1'b0, "R9 flags with select high",
              {pd_full, pd_analog}, 2'b10);
    endtask

    initial begin
        logic [11:0] msbw, rep, exp;
        bit oe_ok;
        repeat (4) @(negedge clk);
        check(dout_oe === 1'b0 && dout === 1'b0 && pd_full === 1'b1 && pd_analog === 1'b0,
              "R1 reset state", {dout_oe, dout, pd_full, pd_analog}, 4'b0010);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2: data clock with select high does nothing.
        for (int k = 0; k < 5; k++) dpulse();
        check(dout_oe === 1'b0 && pd_full === 1'b1, "R2 no read while select high",
              {dout_oe, pd_full}, 2'b01);

        // Table walk: every vector gets a full read.
        for (int v = 0; v < NVEC; v++) begin
            exp = VEC_EXP[v];
            full_read(VEC_IN[v], msbw, rep, oe_ok);
            check(oe_ok, "R3 sampling phase and null bit", oe_ok, 1);
            check(msbw === exp, (exp == 12'h7FF || exp == 12'h800) ?
                  "R10 boundary word top first" : "R4 R8 word top first", msbw, exp);
            check(rep[11:1] === exp[11:1], "R5 repeated word lowest first",
                  rep[11:1], exp[11:1]);
        end

        // R7: abort after four result bits.
        sample_in = 12'hC3A;
        cs_n_in = 1'b0;
        repeat (8) @(negedge clk);
        dpulse();
        dpulse();
        msbw = '0;
        for (int k = 11; k >= 8; k--) begin
            dpulse();
            msbw[k] = dout;
        end
        check(msbw[11:8] === 4'hC, "R7 partial bits before abort", msbw[11:8], 4'hC);
        cs_n_in = 1'b1;
        repeat (4) @(negedge clk);
        check(dout_oe === 1'b0 && pd_full === 1'b1, "R7 abort releases output",
              {dout_oe, pd_full}, 2'b01);
        dpulse();
        dpulse();
        check(dout_oe === 1'b0, "R2 no restart without select fall", dout_oe, 0);

        // R2: a fresh select fall gives a correct full read after the abort.
        full_read(12'h3C5, msbw, rep, oe_ok);
        check(msbw === 12'h3C5 && oe_ok, "R2 read after abort", msbw, 12'h3C5);

        // R1: reset in the middle of a read.
        sample_in = 12'hFFF;
        cs_n_in = 1'b0;
        repeat (8) @(negedge clk);
        dpulse();
        dpulse();
        dpulse();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(dout_oe === 1'b0 && pd_full === 1'b1 && pd_analog === 1'b0,
              "R1 reset mid read", {dout_oe, pd_full, pd_analog}, 3'b010);
        cs_n_in = 1'b1;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule